// File: doc/BRIEF.md
# Load/Store-Pair Micro-Op Expander

This block sits in an instruction decode path and breaks one register-pair memory instruction into a short ordered sequence of micro-ops. A request carries two data registers, a base register, a signed immediate, an access width in bytes (4, 8 or 16), an integer or floating-point flavor, a load or store direction, a sign-extend flag and an addressing mode. The block takes one request, then emits its micro-ops one at a time over a valid/ready stream until the one flagged last has been taken.

Depending on the addressing mode, the sequence may begin with an address-computation step that places base plus immediate in a temporary register, and may end with a base-update step. Loads of a register pair are fused where the width allows. A 16-byte store is split into half-register pieces. Requests with an unsupported width, a 16-byte integer pair, or an undefined mode are refused with a one-cycle error pulse and issue no micro-ops.

Top module: `lsp_pair_expander`

## Requirements
- R1: After reset, out_valid and err are 0 and in_ready is 1.
- R2: While out_valid is 1, out_count gives the sequence length. Loads: (address step ? 1 : 0) + 1 for widths 4 and 8, or 2 for width 16, + (update step ? 1 : 0). Stores: (address step ? 1 : 0) + width/4 + (update step ? 1 : 0).
- R3: Modes are encoded as 0 = offset, 1 = pre-index and 2 = post-index. In modes 0 and 1, the first micro-op is opcode 0 (address step). It has r1 = TMP_REG, areg = base and off = immediate.
- R4: In mode 2 there is no address step, and every memory micro-op has areg = base. In the other modes, areg = TMP_REG.
- R5: Modes 1 and 2 end with opcode 13 (base update), which has r1 = base. In mode 2 it has areg = base and off = immediate. In mode 1 it has areg = TMP_REG and off = 0. Mode 0 has no update step.
- R6: A 16-byte floating-point load issues two opcode-1 micro-ops: r1 = first register at off 0, then r1 = second register at off 16.
- R7: A 16-byte floating-point store issues opcode 7 (low half) and then opcode 8 (high half) for the first register at off 0. It then issues the same pair for the second register at off 16.
- R8: An 8-byte load is one fused micro-op with r1 and r2 set to the two registers at off 0: opcode 2 for integer, opcode 3 for floating point. An 8-byte store is two micro-ops, the first register at off 0 and the second at off 8: opcode 9 for integer, opcode 10 for floating point.
- R9: A 4-byte load is one fused micro-op. It is opcode 4 for an integer load with the sign flag set, opcode 5 for an integer load with the flag clear, and opcode 6 for floating point. A 4-byte store is one fused micro-op: opcode 11 for integer, opcode 12 for floating point. The sign flag has no effect on any other micro-op.
- R10: The final micro-op of a sequence has out_last = 1 and out_dcommit = 0. Every earlier micro-op has out_last = 0 and out_dcommit = 1.
- R11: A request is refused if its width is not 4, 8 or 16, if it is a 16-byte integer request, or if its mode is 3. A refused request raises err for exactly the cycle after acceptance, issues no micro-op, and leaves in_ready at 1.
- R12: in_ready is 0 while a sequence is in flight. A micro-op with out_ready low stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_rt | input | REG_W | First data register |
| in_rt2 | input | REG_W | Second data register |
| in_rn | input | REG_W | Base register |
| in_imm | input | IMM_W | Signed immediate |
| in_size | input | SIZE_W | Access width in bytes |
| in_fp | input | 1 | Floating-point flavor |
| in_load | input | 1 | 1 = load, 0 = store |
| in_sext | input | 1 | Sign-extend for 4-byte integer loads |
| in_mode | input | 2 | Addressing mode |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_op | output | 4 | Micro-op opcode |
| out_r1 | output | REG_W | First register field |
| out_r2 | output | REG_W | Second register field (0 when unused) |
| out_areg | output | REG_W | Address source register |
| out_off | output | IMM_W | Offset field |
| out_last | output | 1 | Final micro-op of the sequence |
| out_dcommit | output | 1 | Commit deferred to the final micro-op |
| out_count | output | 3 | Sequence length, 0 when idle |
| err | output | 1 | Request refused |

## Verification
A corrupted step counter shows up at the ports within one handshake. It can produce a repeated or skipped opcode, an offset out of order, or a last flag on the wrong micro-op. It can also cut the stream short of out_count or run it past out_count. A wrong latched mode or width shows in the first micro-op of the sequence: the address step appears or is missing, or out_areg is wrong. Stalls are applied at random, so any micro-op that changes while held is caught on the next cycle.

// File: rtl/lsp_pkg.sv
// Shared opcodes, mode codes and derived counts for the pair expander.
// Assumes at most six micro-ops per request (address, four stores, update).
package lsp_pkg;
    localparam int MAX_UOPS = 6;
    localparam int CNT_W    = $clog2(MAX_UOPS + 1);

    localparam logic [1:0] MD_OFFSET = 2'd0;
    localparam logic [1:0] MD_PRE    = 2'd1;
    localparam logic [1:0] MD_POST   = 2'd2;

    typedef enum logic [3:0] {
        OP_ADDR    = 4'd0,
        OP_LD_Q    = 4'd1,
        OP_LD_P64  = 4'd2,
        OP_LD_P64F = 4'd3,
        OP_LD_P32S = 4'd4,
        OP_LD_P32Z = 4'd5,
        OP_LD_P32F = 4'd6,
        OP_ST_QLO  = 4'd7,
        OP_ST_QHI  = 4'd8,
        OP_ST_X    = 4'd9,
        OP_ST_XF   = 4'd10,
        OP_ST_P32  = 4'd11,
        OP_ST_P32F = 4'd12,
        OP_WB      = 4'd13,
        OP_NONE    = 4'd15
    } uop_op_e;
endpackage

// File: rtl/lsp_decode.sv
// Request classifier: decides whether a request is legal, how many memory
// micro-ops it needs and the total sequence length.
// Assumes width is given in bytes; purely combinational.
module lsp_decode #(
    parameter int SIZE_W = 5
) (
    input  logic [SIZE_W-1:0]         size,
    input  logic                      fp,
    input  logic                      load,
    input  logic [1:0]                mode,
    output logic                      bad,
    output logic [lsp_pkg::CNT_W-1:0] nmem,
    output logic [lsp_pkg::CNT_W-1:0] cnt
);
    import lsp_pkg::*;

    logic is4, is8, is16;

    // Classify width, legality and micro-op counts.
    always_comb begin
        is4  = (size == SIZE_W'(4));
        is8  = (size == SIZE_W'(8));
        is16 = (size == SIZE_W'(16));
        bad  = !(is4 || is8 || is16) || (is16 && !fp) || (mode == 2'd3);
        if (load)
            nmem = is16 ? CNT_W'(2) : CNT_W'(1);
        else if (is16)
            nmem = CNT_W'(4);
        else if (is8)
            nmem = CNT_W'(2);
        else
            nmem = CNT_W'(1);
        cnt = nmem + ((mode != MD_POST) ? CNT_W'(1) : CNT_W'(0))
                   + ((mode != MD_OFFSET) ? CNT_W'(1) : CNT_W'(0));
    end
endmodule

// File: rtl/lsp_uop_gen.sv
// Micro-op former: maps a step index of a latched request to the fields of
// one micro-op. Assumes step < cnt and that the request was legal.
module lsp_uop_gen #(
    parameter int REG_W   = 5,
    parameter int IMM_W   = 16,
    parameter int SIZE_W  = 5,
    parameter int TMP_REG = 30
) (
    input  logic [lsp_pkg::CNT_W-1:0] step,
    input  logic [lsp_pkg::CNT_W-1:0] cnt,
    input  logic [lsp_pkg::CNT_W-1:0] nmem,
    input  logic                      post,
    input  logic [SIZE_W-1:0]         size,
    input  logic                      fp,
    input  logic                      load,
    input  logic                      sext,
    input  logic [REG_W-1:0]          rt,
    input  logic [REG_W-1:0]          rt2,
    input  logic [REG_W-1:0]          rn,
    input  logic [IMM_W-1:0]          imm,
    output lsp_pkg::uop_op_e          op,
    output logic [REG_W-1:0]          r1,
    output logic [REG_W-1:0]          r2,
    output logic [REG_W-1:0]          areg,
    output logic [IMM_W-1:0]          off,
    output logic                      last,
    output logic                      dcommit
);
    import lsp_pkg::*;

    logic [CNT_W-1:0] m;
    logic [REG_W-1:0] abase;

    // Select the micro-op for this step: address, memory or update.
    always_comb begin
        abase = post ? rn : REG_W'(TMP_REG);
        m     = post ? step : step - CNT_W'(1);
        op    = OP_NONE;
        r1    = '0;
        r2    = '0;
        areg  = abase;
        off   = '0;
        if (!post && step == '0) begin
            op   = OP_ADDR;
            r1   = REG_W'(TMP_REG);
            areg = rn;
            off  = imm;
        end else if (m < nmem) begin
            if (load) begin
                if (size == SIZE_W'(16)) begin
                    op  = OP_LD_Q;
                    r1  = (m == '0) ? rt : rt2;
                    off = (m == '0) ? '0 : IMM_W'(16);
                end else if (size == SIZE_W'(8)) begin
                    op = fp ? OP_LD_P64F : OP_LD_P64;
                    r1 = rt;
                    r2 = rt2;
                end else begin
                    op = fp ? OP_LD_P32F : (sext ? OP_LD_P32S : OP_LD_P32Z);
                    r1 = rt;
                    r2 = rt2;
                end
            end else begin
                if (size == SIZE_W'(16)) begin
                    op  = m[0] ? OP_ST_QHI : OP_ST_QLO;
                    r1  = m[1] ? rt2 : rt;
                    off = m[1] ? IMM_W'(16) : '0;
                end else if (size == SIZE_W'(8)) begin
                    op  = fp ? OP_ST_XF : OP_ST_X;
                    r1  = m[0] ? rt2 : rt;
                    off = m[0] ? IMM_W'(8) : '0;
                end else begin
                    op = fp ? OP_ST_P32F : OP_ST_P32;
                    r1 = rt;
                    r2 = rt2;
                end
            end
        end else begin
            op  = OP_WB;
            r1  = rn;
            off = post ? imm : '0;
        end
        last    = (step == cnt - CNT_W'(1));
        dcommit = !last;
    end
endmodule

// File: rtl/lsp_pair_expander.sv
// Pair-instruction expander top: accepts one request, latches it, and steps
// through its micro-ops on a valid/ready stream. Refused requests pulse err.
// Assumes synchronous active-low reset; one request in flight at a time.
module lsp_pair_expander #(
    parameter int REG_W   = 5,
    parameter int IMM_W   = 16,
    parameter int SIZE_W  = 5,
    parameter int TMP_REG = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [REG_W-1:0]  in_rt,
    input  logic [REG_W-1:0]  in_rt2,
    input  logic [REG_W-1:0]  in_rn,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [SIZE_W-1:0] in_size,
    input  logic              in_fp,
    input  logic              in_load,
    input  logic              in_sext,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [3:0]        out_op,
    output logic [REG_W-1:0]  out_r1,
    output logic [REG_W-1:0]  out_r2,
    output logic [REG_W-1:0]  out_areg,
    output logic [IMM_W-1:0]  out_off,
    output logic              out_last,
    output logic              out_dcommit,
    output logic [2:0]        out_count,
    output logic              err
);
    import lsp_pkg::*;

    logic              busy_q, err_q;
    logic [CNT_W-1:0]  step_q, cnt_q, nmem_q;
    logic [REG_W-1:0]  rt_q, rt2_q, rn_q;
    logic [IMM_W-1:0]  imm_q;
    logic [SIZE_W-1:0] size_q;
    logic              fp_q, load_q, sext_q, post_q;
    logic              dec_bad;
    logic [CNT_W-1:0]  dec_nmem, dec_cnt;
    uop_op_e           gen_op;
    logic              gen_last;
    logic              accept;

    lsp_decode #(.SIZE_W(SIZE_W)) u_decode (
        .size (in_size),
        .fp   (in_fp),
        .load (in_load),
        .mode (in_mode),
        .bad  (dec_bad),
        .nmem (dec_nmem),
        .cnt  (dec_cnt)
    );

    lsp_uop_gen #(
        .REG_W(REG_W), .IMM_W(IMM_W), .SIZE_W(SIZE_W), .TMP_REG(TMP_REG)
    ) u_gen (
        .step    (step_q),
        .cnt     (cnt_q),
        .nmem    (nmem_q),
        .post    (post_q),
        .size    (size_q),
        .fp      (fp_q),
        .load    (load_q),
        .sext    (sext_q),
        .rt      (rt_q),
        .rt2     (rt2_q),
        .rn      (rn_q),
        .imm     (imm_q),
        .op      (gen_op),
        .r1      (out_r1),
        .r2      (out_r2),
        .areg    (out_areg),
        .off     (out_off),
        .last    (gen_last),
        .dcommit (out_dcommit)
    );

    assign accept    = in_valid && in_ready;
    assign in_ready  = !busy_q;
    assign out_valid = busy_q;
    assign out_op    = gen_op;
    assign out_last  = gen_last;
    assign out_count = busy_q ? 3'(cnt_q) : 3'd0;
    assign err       = err_q;

    // Latch requests, pulse refusals, and advance the step on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            err_q  <= 1'b0;
            step_q <= '0;
            cnt_q  <= '0;
            nmem_q <= '0;
            rt_q   <= '0;
            rt2_q  <= '0;
            rn_q   <= '0;
            imm_q  <= '0;
            size_q <= '0;
            fp_q   <= 1'b0;
            load_q <= 1'b0;
            sext_q <= 1'b0;
            post_q <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (accept) begin
                if (dec_bad) begin
                    err_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                    step_q <= '0;
                    cnt_q  <= dec_cnt;
                    nmem_q <= dec_nmem;
                    rt_q   <= in_rt;
                    rt2_q  <= in_rt2;
                    rn_q   <= in_rn;
                    imm_q  <= in_imm;
                    size_q <= in_size;
                    fp_q   <= in_fp;
                    load_q <= in_load;
                    sext_q <= in_sext;
                    post_q <= (in_mode == MD_POST);
                end
            end else if (busy_q && out_ready) begin
                if (gen_last)
                    busy_q <= 1'b0;
                else
                    step_q <= step_q + CNT_W'(1);
            end
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!out_valid && !err && in_ready));

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count != 3'd0 && out_count <= 3'(MAX_UOPS)));

    assert_addr_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_valid) && !post_q) |-> (out_op == 4'(OP_ADDR)));

    assert_post_no_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && post_q) |-> (out_op != 4'(OP_ADDR) && out_areg == rn_q));

    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last != out_dcommit));

    assert_stream_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);

    assert_err_no_uop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!out_valid && in_ready));

    assert_hold_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable({out_op, out_r1, out_r2, out_areg, out_off, out_last})));

    assert_busy_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
endmodule

// File: tb/lsp_pair_expander_bench.sv
module lsp_pair_expander_bench;
    localparam int CLK_PERIOD = 10;
    localparam int REG_W = 5;
    localparam int IMM_W = 16;
    localparam int SIZE_W = 5;
    localparam int TMP = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [REG_W-1:0] in_rt = '0, in_rt2 = '0, in_rn = '0;
    logic [IMM_W-1:0] in_imm = '0;
    logic [SIZE_W-1:0] in_size = '0;
    logic in_fp = 1'b0, in_load = 1'b0, in_sext = 1'b0;
    logic [1:0] in_mode = '0;
    logic out_valid, out_ready = 1'b0;
    logic [3:0] out_op;
    logic [REG_W-1:0] out_r1, out_r2, out_areg;
    logic [IMM_W-1:0] out_off;
    logic out_last, out_dcommit, err;
    logic [2:0] out_count;

    int tests = 0;
    int fails = 0;

    logic [3:0]       e_op [8];
    logic [REG_W-1:0] e_r1 [8];
    logic [REG_W-1:0] e_r2 [8];
    logic [REG_W-1:0] e_ar [8];
    logic [IMM_W-1:0] e_off [8];
    int e_n;
    bit e_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsp_pair_expander #(.REG_W(REG_W), .IMM_W(IMM_W), .SIZE_W(SIZE_W), .TMP_REG(TMP)) u_lsp_pair_expander (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_rt(in_rt), .in_rt2(in_rt2), .in_rn(in_rn), .in_imm(in_imm),
        .in_size(in_size), .in_fp(in_fp), .in_load(in_load), .in_sext(in_sext),
        .in_mode(in_mode), .out_valid(out_valid), .out_ready(out_ready),
        .out_op(out_op), .out_r1(out_r1), .out_r2(out_r2), .out_areg(out_areg),
        .out_off(out_off), .out_last(out_last), .out_dcommit(out_dcommit),
        .out_count(out_count), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input int op, input logic [REG_W-1:0] r1, input logic [REG_W-1:0] r2,
                        input logic [REG_W-1:0] ar, input logic [IMM_W-1:0] off);
        e_op[e_n] = 4'(op); e_r1[e_n] = r1; e_r2[e_n] = r2;
        e_ar[e_n] = ar; e_off[e_n] = off;
        e_n++;
    endtask

    // Expected sequence built directly from the requirement text.
    task automatic build_exp(input int sz, input bit fp, input bit ld, input bit sx, input int md,
                             input logic [REG_W-1:0] rt, input logic [REG_W-1:0] rt2,
                             input logic [REG_W-1:0] rn, input logic [IMM_W-1:0] imm);
        logic [REG_W-1:0] ar;
        bit post;
        e_n = 0;
        e_bad = !(sz == 4 || sz == 8 || sz == 16) || (sz == 16 && !fp) || md == 3;
        if (e_bad) return;
        post = (md == 2);
        ar = post ? rn : REG_W'(TMP);
        if (!post) push(0, REG_W'(TMP), '0, rn, imm);
        if (ld) begin
            if (sz == 16) begin
                push(1, rt, '0, ar, '0);
                push(1, rt2, '0, ar, 16);
            end else if (sz == 8) push(fp ? 3 : 2, rt, rt2, ar, '0);
            else push(fp ? 6 : (sx ? 4 : 5), rt, rt2, ar, '0);
        end else begin
            if (sz == 16) begin
                push(7, rt, '0, ar, '0);
                push(8, rt, '0, ar, '0);
                push(7, rt2, '0, ar, 16);
                push(8, rt2, '0, ar, 16);
            end else if (sz == 8) begin
                push(fp ? 10 : 9, rt, '0, ar, '0);
                push(fp ? 10 : 9, rt2, '0, ar, 8);
            end else push(fp ? 12 : 11, rt, rt2, ar, '0);
        end
        if (md != 0) push(13, rn, '0, ar, post ? imm : '0);
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R3";
            4'd1: return "R6";
            4'd7, 4'd8: return "R7";
            4'd2, 4'd3, 4'd9, 4'd10: return "R8";
            4'd13: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic run_req(input int sz, input bit fp, input bit ld, input bit sx, input int md,
                           input logic [REG_W-1:0] rt, input logic [REG_W-1:0] rt2,
                           input logic [REG_W-1:0] rn, input logic [IMM_W-1:0] imm);
        int idx;
        int guard;
        build_exp(sz, fp, ld, sx, md, rt, rt2, rn, imm);
        @(negedge clk);
        in_valid = 1'b1; in_size = SIZE_W'(sz); in_fp = fp; in_load = ld;
        in_sext = sx; in_mode = 2'(md); in_rt = rt; in_rt2 = rt2; in_rn = rn; in_imm = imm;
        chk(in_ready == 1'b1, "R12", "in_ready idle", 64'(in_ready), 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (e_bad) begin
            chk(err == 1'b1 && out_valid == 1'b0, "R11", "err pulse",
                {err, out_valid}, 2'b10);
            @(negedge clk);
            chk(err == 1'b0 && out_valid == 1'b0 && in_ready == 1'b1, "R11", "after refuse",
                {err, out_valid, in_ready}, 3'b001);
            return;
        end
        chk(in_ready == 1'b0, "R12", "in_ready busy", 64'(in_ready), 0);
        idx = 0;
        guard = 0;
        while (idx < e_n && guard < 200) begin
            out_ready = ($urandom % 4) != 0;
            chk(out_valid == 1'b1, "R12", "valid held", 64'(out_valid), 1);
            chk(32'(out_count) == e_n, "R2", "count", 64'(out_count), 64'(e_n));
            chk(out_op == e_op[idx] && out_r1 == e_r1[idx] && out_r2 == e_r2[idx]
                && out_off == e_off[idx], tag_of(e_op[idx]), "uop fields",
                {out_op, out_r1, out_r2, out_off}, {e_op[idx], e_r1[idx], e_r2[idx], e_off[idx]});
            chk(out_areg == e_ar[idx], "R4", "address reg", 64'(out_areg), 64'(e_ar[idx]));
            chk(out_last == (idx == e_n - 1) && out_dcommit == (idx != e_n - 1), "R10", "flags",
                {out_last, out_dcommit}, {idx == e_n - 1, idx != e_n - 1});
            if (out_ready) idx++;
            guard++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R10", "stream ended",
            {out_valid, in_ready}, 2'b01);
    endtask

    initial begin
        repeat (CLK_PERIOD * 15000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0 && err == 1'b0 && in_ready == 1'b1, "R1", "reset state",
            {out_valid, err, in_ready}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", "after release",
            {out_valid, in_ready}, 2'b01);
        // Directed sweep over width, direction, flavor and mode.
        foreach (e_op[k]) e_op[k] = '0;
        for (int s = 0; s < 3; s++)
            for (int l = 0; l < 2; l++)
                for (int f = 0; f < 2; f++)
                    for (int m = 0; m < 3; m++)
                        run_req(4 << s, f[0], l[0], 1'b0, m, 5'd3, 5'd7, 5'd12, 16'h0040);
        // R9 sign flag on 4-byte integer loads and on other widths.
        run_req(4, 1'b0, 1'b1, 1'b1, 1, 5'd1, 5'd2, 5'd31, 16'hFFF8);
        run_req(8, 1'b0, 1'b1, 1'b1, 2, 5'd1, 5'd2, 5'd31, 16'hFFF8);
        run_req(8, 1'b0, 1'b0, 1'b1, 0, 5'd9, 5'd10, 5'd4, 16'h0010);
        // R11 refused requests.
        run_req(12, 1'b1, 1'b1, 1'b0, 0, 5'd1, 5'd2, 5'd3, 16'h0);
        run_req(16, 1'b0, 1'b0, 1'b0, 1, 5'd1, 5'd2, 5'd3, 16'h0);
        run_req(8, 1'b0, 1'b1, 1'b0, 3, 5'd1, 5'd2, 5'd3, 16'h0);
        run_req(0, 1'b1, 1'b0, 1'b0, 2, 5'd1, 5'd2, 5'd3, 16'h0);
        // Constrained random mix.
        for (int i = 0; i < 300; i++) begin
            int sz;
            int r;
            r = $urandom % 10;
            sz = (r < 3) ? 4 : (r < 6) ? 8 : (r < 9) ? 16 : int'($urandom % 32);
            run_req(sz, 1'($urandom % 4 != 0), 1'($urandom), 1'($urandom),
                    ($urandom % 16 == 0) ? 3 : int'($urandom % 3),
                    5'($urandom), 5'($urandom), 5'($urandom), 16'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule